// File: doc/BRIEF.md
# Password-Gated Flash Program/Erase Lock Register

This block is a 32-bit register that sits in a flash controller's register space and decides which flash regions may be programmed or erased. It holds one lock bit for a test/shadow region, two for mid-space blocks and sixteen for low-space blocks. After reset every lock bit is loaded from a nonvolatile configuration input. Software cannot change any lock bit until it has written a fixed 32-bit password. That write sets a sticky enable flag, and the flag stays set until the next reset.

Lock writes are also refused while a program/erase operation is in flight, meaning from the interlock-accepted pulse until the done indication, and while a high-voltage operation is suspended. Blocks that are absent from the configured memory size are locked permanently. Each effective lock output is the OR of the register bit and a secondary lock input.

Bit numbers below use conventional numbering: bit 31 is the most significant bit.

Top module: `flash_lock_reg`

## Requirements
- R1: A write whose full 32-bit data equals 0xA1A11111 sets the enable flag, which reads back in bit 31. A write of any other value leaves the flag unchanged.
- R2: Once set, the enable flag stays 1 until reset, even when a later write carries 0 in bit 31. Reset clears it.
- R3: While the enable flag is 0, writes leave every lock bit unchanged.
- R4: A qualified write copies write data bit 20 into the test/shadow lock, bits 17:16 into the mid-space locks (mid[1] in bit 17) and bits 15:0 into the low-space locks (low[i] in bit i). A write is qualified when it is enabled, not frozen and not a password write. Reserved bits 30:21 and 19:18 always read 0.
- R5: Lock writes are ignored in the cycle of the interlock pulse. They stay ignored in every later cycle until the cycle in which the done input is high; a write in that done cycle is accepted. Writes are also ignored in any cycle in which the suspend input is high.
- R6: Reset loads the lock bits from the configuration input `cfg_lock`, ordered {test, mid[1:0], low[15:0]}. A value of all ones locks everything.
- R7: Each effective lock output is 1 when its register bit is 1 or its secondary lock input is 1.
- R8: A block marked absent by the build-time present mask resets to 1, reads 1 and ignores writes. By default both mid-space blocks are absent.
- R9: A password write never updates the lock bits in the same cycle, even when the flag is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back image of the register |
| cfg_lock | input | 19 | Nonvolatile lock defaults {test, mid[1:0], low[15:0]} |
| ilk_pulse | input | 1 | Interlock write accepted (one-cycle pulse) |
| op_done | input | 1 | Program/erase operation done |
| hv_susp | input | 1 | High-voltage operation suspended |
| sec_lock_ts | input | 1 | Secondary lock for the test/shadow region |
| sec_lock_mid | input | 2 | Secondary locks for the mid-space blocks |
| sec_lock_low | input | 16 | Secondary locks for the low-space blocks |
| eff_lock_ts | output | 1 | Effective test/shadow lock |
| eff_lock_mid | output | 2 | Effective mid-space locks |
| eff_lock_low | output | 16 | Effective low-space locks |

## Verification
Write data is varied between all zeros, all ones, a mixed pattern and the password. These values separate correct field placement from reserved-bit leakage, and a real lock update from the password write leaving the locks alone. Near-miss passwords and writes made before enabling show that only the exact word opens the register. The same writes are issued during an interlock window, in the done cycle and under suspend, which pins down where the freeze starts and where it ends. A second reset with a patterned configuration word shows which bits are loaded and which absent blocks are forced to 1.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int N_LOW   = 16;
  localparam int N_MID   = 2;
  localparam int N_LOCK  = 1 + N_MID + N_LOW;
  localparam int BIT_EN  = 31;
  localparam int BIT_TS  = 20;
  localparam int MID_LSB = 16;
  localparam int LOW_LSB = 0;

  // Place a lock vector {ts, mid, low} and the enable flag into the register image.
  function automatic logic [31:0] to_word(logic en, logic [N_LOCK-1:0] l);
    logic [31:0] w;
    w = '0;
    w[BIT_EN] = en;
    w[BIT_TS] = l[N_LOCK-1];
    w[MID_LSB +: N_MID] = l[N_LOW +: N_MID];
    w[LOW_LSB +: N_LOW] = l[N_LOW-1:0];
    return w;
  endfunction

  // Extract the lock vector from a written data word.
  function automatic logic [N_LOCK-1:0] from_word(logic [31:0] w);
    return {w[BIT_TS], w[MID_LSB +: N_MID], w[LOW_LSB +: N_LOW]};
  endfunction

  // Absent blocks are pinned to locked.
  function automatic logic [N_LOCK-1:0] pin_absent(logic [N_LOCK-1:0] v,
                                                    logic [N_LOCK-1:0] present);
    return v | ~present;
  endfunction
endpackage

// File: rtl/lock_wr_gate.sv
module lock_wr_gate #(
  parameter logic [31:0] PASSWORD = 32'hA1A1_1111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        ilk_pulse,
  input  logic        op_done,
  input  logic        hv_susp,
  output logic        en_q,
  output logic        freeze_q,
  output logic        pw_hit,
  output logic        frozen,
  output logic        lock_we
);
  assign pw_hit  = wr_en && (wr_data == PASSWORD);
  assign frozen  = ilk_pulse | hv_susp | (freeze_q & ~op_done);
  assign lock_we = wr_en & en_q & ~frozen & ~pw_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      freeze_q <= 1'b0;
    end else begin
      if (pw_hit) en_q <= 1'b1;
      freeze_q <= ilk_pulse | (freeze_q & ~op_done);
    end
  end
endmodule

// File: rtl/lock_cell_array.sv
module lock_cell_array #(
  parameter int              N       = 19,
  parameter logic [N-1:0]    PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] cfg,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  import flash_lock_pkg::*;

  logic [N-1:0] rst_v;
  logic [N-1:0] wr_v;

  assign rst_v = pin_absent(cfg, PRESENT);
  assign wr_v  = pin_absent(wdata, PRESENT);

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)  q[i] <= rst_v[i];
      else if (we) q[i] <= wr_v[i];
    end
  end
endmodule

// File: rtl/flash_lock_reg.sv
module flash_lock_reg
  import flash_lock_pkg::*;
#(
  parameter logic [31:0]      PASSWORD    = 32'hA1A1_1111,
  parameter logic             TS_PRESENT  = 1'b1,
  parameter logic [N_MID-1:0] MID_PRESENT = '0,
  parameter logic [N_LOW-1:0] LOW_PRESENT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [N_LOCK-1:0] cfg_lock,
  input  logic              ilk_pulse,
  input  logic              op_done,
  input  logic              hv_susp,
  input  logic              sec_lock_ts,
  input  logic [N_MID-1:0]  sec_lock_mid,
  input  logic [N_LOW-1:0]  sec_lock_low,
  output logic              eff_lock_ts,
  output logic [N_MID-1:0]  eff_lock_mid,
  output logic [N_LOW-1:0]  eff_lock_low
);
  localparam logic [N_LOCK-1:0] PRESENT = {TS_PRESENT, MID_PRESENT, LOW_PRESENT};

  logic              en_q;
  logic              freeze_q;
  logic              pw_hit;
  logic              frozen;
  logic              lock_we;
  logic [N_LOCK-1:0] lock_q;

  lock_wr_gate #(.PASSWORD(PASSWORD)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ilk_pulse(ilk_pulse), .op_done(op_done), .hv_susp(hv_susp),
    .en_q(en_q), .freeze_q(freeze_q), .pw_hit(pw_hit),
    .frozen(frozen), .lock_we(lock_we)
  );

  lock_cell_array #(.N(N_LOCK), .PRESENT(PRESENT)) u_cells (
    .clk(clk), .rst_n(rst_n), .we(lock_we), .cfg(cfg_lock),
    .wdata(from_word(wr_data)), .q(lock_q)
  );

  assign rd_data      = to_word(en_q, lock_q);
  assign eff_lock_ts  = lock_q[N_LOCK-1] | sec_lock_ts;
  assign eff_lock_mid = lock_q[N_LOW +: N_MID] | sec_lock_mid;
  assign eff_lock_low = lock_q[N_LOW-1:0] | sec_lock_low;
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk
  import flash_lock_pkg::*;
#(
  parameter logic [31:0]      PASSWORD    = 32'hA1A1_1111,
  parameter logic             TS_PRESENT  = 1'b1,
  parameter logic [N_MID-1:0] MID_PRESENT = '0,
  parameter logic [N_LOW-1:0] LOW_PRESENT = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             ilk_pulse,
  input logic             hv_susp,
  input logic [31:0]      rd_data,
  input logic [N_LOW-1:0] sec_lock_low,
  input logic [N_LOW-1:0] eff_lock_low,
  input logic             lock_we
);
  localparam logic [N_LOCK-1:0] PRES  = {TS_PRESENT, MID_PRESENT, LOW_PRESENT};
  localparam logic [31:0] LOCK_IMG    = to_word(1'b0, '1);
  localparam logic [31:0] ABSENT_IMG  = to_word(1'b0, ~PRES);
  localparam logic [31:0] RSV_IMG     = ~to_word(1'b1, '1);

  // R1
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[BIT_EN]) |-> $past(wr_en && wr_data == PASSWORD));
  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_EN] |=> rd_data[BIT_EN]);
  // R3
  locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[BIT_EN] |=> $stable(rd_data & LOCK_IMG));
  // R3
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |-> rd_data[BIT_EN]);
  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSV_IMG) == 32'h0);
  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ilk_pulse || hv_susp) |=> $stable(rd_data & LOCK_IMG));
  // R7
  sec_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_lock_low & ~eff_lock_low) == '0);
  // R8
  absent_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ABSENT_IMG) == ABSENT_IMG);
  // R9
  pw_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == PASSWORD) |=> $stable(rd_data & LOCK_IMG));
endmodule

bind flash_lock_reg flash_lock_chk #(
  .PASSWORD(PASSWORD), .TS_PRESENT(TS_PRESENT),
  .MID_PRESENT(MID_PRESENT), .LOW_PRESENT(LOW_PRESENT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ilk_pulse(ilk_pulse), .hv_susp(hv_susp), .rd_data(rd_data),
  .sec_lock_low(sec_lock_low), .eff_lock_low(eff_lock_low), .lock_we(lock_we)
);

// File: tb/flash_lock_reg_test.sv
module flash_lock_reg_test;
  localparam logic [31:0] PW    = 32'hA1A1_1111;
  localparam logic [31:0] LOCKS = 32'h0013_FFFF;  // bits 20, 17:16, 15:0
  localparam logic [31:0] ABS   = 32'h0003_0000;  // mid blocks absent

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [18:0] cfg_lock = 19'h7FFFF;
  logic        ilk_pulse = 1'b0, op_done = 1'b0, hv_susp = 1'b0;
  logic        sec_lock_ts = 1'b0;
  logic [1:0]  sec_lock_mid = '0;
  logic [15:0] sec_lock_low = '0;
  logic        eff_lock_ts;
  logic [1:0]  eff_lock_mid;
  logic [15:0] eff_lock_low;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_lock_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cfg_lock(cfg_lock), .ilk_pulse(ilk_pulse), .op_done(op_done), .hv_susp(hv_susp),
    .sec_lock_ts(sec_lock_ts), .sec_lock_mid(sec_lock_mid), .sec_lock_low(sec_lock_low),
    .eff_lock_ts(eff_lock_ts), .eff_lock_mid(eff_lock_mid), .eff_lock_low(eff_lock_low)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          model_ok = 0;
  logic        en_m, fr_m;
  logic [31:0] img_m;
  always @(posedge clk) begin
    if (!rst_n) begin
      en_m = 0; fr_m = 0;
      img_m = '0;
      img_m[20]    = cfg_lock[18];
      img_m[17:16] = 2'b11;
      img_m[15:0]  = cfg_lock[15:0];
      model_ok = 1;
    end else if (model_ok) begin
      bit blocked, pw;
      blocked = ilk_pulse || hv_susp || (fr_m && !op_done);
      pw = wr_en && (wr_data == PW);
      if (wr_en && en_m && !blocked && !pw) img_m = (wr_data & LOCKS) | ABS;
      if (pw) en_m = 1;
      fr_m = ilk_pulse || (fr_m && !op_done);
    end
  end

  always @(posedge clk) begin
    #3;
    if (model_ok && !finished) begin
      check(rd_data, img_m | {en_m, 31'h0}, "R4 model read-back");
      check({13'h0, eff_lock_ts, eff_lock_mid, eff_lock_low},
            {13'h0, img_m[20] | sec_lock_ts, img_m[17:16] | sec_lock_mid,
             img_m[15:0] | sec_lock_low}, "R7 model effective locks");
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset(input logic [18:0] cfg);
    @(negedge clk); rst_n = 1'b0; cfg_lock = cfg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 R8: erased configuration locks everything
    check(rd_data, 32'h0013_FFFF, "R6 reset load all ones");
    check({15'h0, eff_lock_ts, eff_lock_low}, {15'h0, 1'b1, 16'hFFFF}, "R6 effective after reset");
    wr(32'h0);
    check(rd_data, 32'h0013_FFFF, "R3 write before enable");
    wr(32'hA1A1_1110);
    check(rd_data, 32'h0013_FFFF, "R1 near-miss password");
    wr(PW);
    check(rd_data, 32'h8013_FFFF, "R1 R9 password sets enable only");
    wr(32'h0);
    check(rd_data, 32'h8003_0000, "R4 R8 clear locks, mid stays");
    check({16'h0, eff_lock_low}, 32'h0, "R7 unlocked low");
    @(negedge clk); sec_lock_low = 16'h00F0; sec_lock_ts = 1'b1;
    @(negedge clk);
    check({15'h0, eff_lock_ts, eff_lock_low}, {15'h0, 1'b1, 16'h00F0}, "R7 secondary lock");
    sec_lock_low = '0; sec_lock_ts = 1'b0;
    wr(32'hFFFF_FFFF);
    check(rd_data, 32'h8013_FFFF, "R4 reserved bits read 0");
    wr(32'h1234_5678);
    check(rd_data, 32'h8013_5678, "R4 mixed pattern");
    wr(PW);
    check(rd_data, 32'h8013_5678, "R9 password with enable set");
    @(negedge clk); ilk_pulse = 1'b1;
    @(negedge clk); ilk_pulse = 1'b0;
    wr(32'h0);
    check(rd_data, 32'h8013_5678, "R5 frozen after interlock");
    @(negedge clk); op_done = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_00FF;
    @(negedge clk); op_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    check(rd_data, 32'h8003_00FF, "R5 write in done cycle accepted");
    @(negedge clk); hv_susp = 1'b1;
    wr(32'h0);
    check(rd_data, 32'h8003_00FF, "R5 suspended");
    hv_susp = 1'b0;
    wr(32'h0);
    check(rd_data, 32'h8003_0000, "R5 after suspend released");
    wr(32'h7FFF_FFFF);
    check(rd_data, 32'h8013_FFFF, "R2 enable not cleared by write");
    do_reset(19'h05555);
    check(rd_data, 32'h0003_5555, "R6 R8 R2 patterned reset");
    wr(PW);
    wr(32'h0010_0000);
    check(rd_data, 32'h8013_0000, "R8 absent mid ignores writes");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule